// File: doc/BRIEF.md
# Parallel Display Bus Write Controller

This block is a write-only master for the two common parallel display buses. One style uses an active-low write strobe, and the display latches data on the strobe's rising edge. The other style uses a clocked enable with a read/write line, and the display latches data on the falling edge of the enable. A single sequencer drives both styles at data widths of 8, 9 or 16 bits. Each transaction starts with an optional command byte, sent with data/command low. A burst of data words follows, sent with data/command high. Chip select stays asserted once for the whole transaction.

The host starts a transaction with a one-cycle `start_i`. The bus style, width, optional command and whether a data burst follows are sampled in that cycle. Data words then arrive on a valid/ready stream, and a last-word flag ends the burst. Each strobe phase lasts at least `PHASE_CYC` clock cycles. A separate request input drives the display reset line low for a programmable number of cycles.

Top module: `pbus_disp_wr`

## Requirements
- R1: `mode_i` encodes the bus style in bit 2 (0 = write-strobe style, 1 = clocked-enable style) and the width in bits 1:0 (0 = 8, 1 = 9, 2 = 16 bits). A start with width code 3 (mode 3 or 7) pulses `err_o` for one cycle, and neither chip select nor any strobe moves.
- R2: `cs_n_o` falls once per transaction, on the edge that accepts the start. It stays low through the command and every data word, and rises only after the inactive phase that follows the last strobe.
- R3: In the write-strobe style, `wr_o` falls first. The word appears on `dbus_o` one cycle later, and `wr_o` then rises, which is the latching edge.
- R4: In the clocked-enable style, `wr_o` stays low for the whole transaction. For each word, `en_o` rises, the word appears one cycle later, and `en_o` falls, which is the latching edge.
- R5: `dc_o` is low while the command word is latched. It is driven high before the first data word and stays high for the rest of the burst.
- R6: When no command is requested, the transaction goes straight to the data words with `dc_o` already high at the first latching edge.
- R7: A start with a command and no data burst latches exactly one word, and `dc_o` never goes high during that transaction.
- R8: After reset the idle levels are: `wr_o`=1, `rd_o`=1 (always, since reads are never issued), `en_o`=0, `cs_n_o`=1, `dc_o`=0, `dbus_o`=0, `disp_rst_n_o`=1, `busy_o`=0 and `wr_ready_o`=0.
- R9: A cycle with `rst_req_i` high and a non-zero `rst_len_i` drives `disp_rst_n_o` low for exactly `rst_len_i` cycles. A length of 0 gives no pulse, and requests made while a pulse is running are ignored.
- R10: Each strobe phase, active and inactive, lasts at least `PHASE_CYC` cycles (minimum 2). The data bus does not change in the cycle of the latching edge.
- R11: `busy_o` is high from the start edge until chip select rises. `wr_ready_o` is high only while the controller waits for a data word. A start arriving while busy, including one with a different mode, has no effect on the running transaction.
- R12: In 8-bit width only `dbus_o[7:0]` carry data, and in 9-bit width only `dbus_o[8:0]` carry data. The upper lines are driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transaction (sampled while idle) |
| mode_i | input | 3 | Bus style (bit 2) and width code (bits 1:0) |
| has_cmd_i | input | 1 | A command word precedes the burst |
| has_data_i | input | 1 | A data burst follows |
| cmd_i | input | 8 | Command byte |
| wr_valid_i | input | 1 | Data word valid |
| wr_data_i | input | DW | Data word |
| wr_last_i | input | 1 | Marks the final word of the burst |
| wr_ready_o | output | 1 | Controller takes a word this cycle when valid |
| busy_o | output | 1 | Transaction in progress |
| err_o | output | 1 | One-cycle pulse on an unsupported mode |
| rst_req_i | input | 1 | Request a display reset pulse |
| rst_len_i | input | RLW | Reset pulse length in cycles |
| dbus_o | output | DW | Parallel data bus |
| cs_n_o | output | 1 | Chip select, active low |
| dc_o | output | 1 | Data/command select, 0 = command |
| wr_o | output | 1 | Write strobe, or read/write select in enable style |
| rd_o | output | 1 | Read strobe, held inactive high |
| en_o | output | 1 | Enable strobe of the clocked-enable style |
| disp_rst_n_o | output | 1 | Display reset, active low |

## Verification
A scoreboard records every word the display would latch, tagged with the level of `dc_o`, and compares it with the queue built from the requested command and words. Transactions are run in both bus styles at all three widths. They cover command plus burst, burst without command, command without burst, and a single-word burst. This separates the strobe polarity per style, the data/command ordering and the narrow-width masking, for which the stimulus words deliberately carry set upper bits. Invalid mode codes, a start issued mid-transaction and reset pulses of lengths 5, 1 and 0 check the rejection, ignore and pulse-length rules at the ports.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    W8  = 2'd0,
    W9  = 2'd1,
    W16 = 2'd2
  } width_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_ACT,
    S_INACT,
    S_WAIT
  } state_e;

  function automatic logic mode_ok(input logic [2:0] m);
    return m[1:0] != 2'b11;
  endfunction
endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
  parameter int PH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic first_o,
  output logic done_o
);
  localparam int CW = $clog2(PH) + 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = (cnt_q == '0);
  assign done_o  = (cnt_q == CW'(PH - 1));
endmodule

// File: rtl/pbus_lane_fmt.sv
module pbus_lane_fmt #(
  parameter int DW = 16
) (
  input  pbus_pkg::width_e wsel_i,
  input  logic [DW-1:0]    din_i,
  output logic [DW-1:0]    dout_o
);
  import pbus_pkg::*;
  for (genvar b = 0; b < DW; b++) begin : g_lane
    if (b < 8) begin : g_base
      assign dout_o[b] = din_i[b];
    end else if (b == 8) begin : g_ninth
      assign dout_o[b] = din_i[b] & (wsel_i != W8);
    end else begin : g_wide
      assign dout_o[b] = din_i[b] & (wsel_i == W16);
    end
  end
endmodule

// File: rtl/pbus_rst_pulse.sv
module pbus_rst_pulse #(
  parameter int RLW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_i,
  input  logic [RLW-1:0] len_i,
  output logic           rst_n_o
);
  logic [RLW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_o <= 1'b1;
      left_q  <= '0;
    end else if (rst_n_o) begin
      if (req_i && len_i != '0) begin
        rst_n_o <= 1'b0;
        left_q  <= len_i;
      end
    end else if (left_q == RLW'(1)) begin
      rst_n_o <= 1'b1;
      left_q  <= '0;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end

  AST_PULSE_COUNTED: assert property (@(posedge clk) disable iff (rst)
    !rst_n_o |-> (left_q != '0)); // R9
endmodule

// File: rtl/pbus_disp_wr.sv
module pbus_disp_wr #(
  parameter int DW        = 16,
  parameter int PHASE_CYC = 2,
  parameter int RLW       = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [2:0]     mode_i,
  input  logic           has_cmd_i,
  input  logic           has_data_i,
  input  logic [7:0]     cmd_i,
  input  logic           wr_valid_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           wr_last_i,
  output logic           wr_ready_o,
  output logic           busy_o,
  output logic           err_o,
  input  logic           rst_req_i,
  input  logic [RLW-1:0] rst_len_i,
  output logic [DW-1:0]  dbus_o,
  output logic           cs_n_o,
  output logic           dc_o,
  output logic           wr_o,
  output logic           rd_o,
  output logic           en_o,
  output logic           disp_rst_n_o
);
  import pbus_pkg::*;

  localparam int PH = (PHASE_CYC < 2) ? 2 : PHASE_CYC;

  state_e        state_q;
  width_e        wsel_q;
  logic          style6800_q;
  logic          is_cmd_q;
  logic          has_data_q;
  logic          last_q;
  logic [DW-1:0] word_q;
  logic [DW-1:0] fmt_word;
  logic          tmr_clr, tmr_first, tmr_done;
  logic          finish;

  assign tmr_clr = !(state_q == S_ACT || state_q == S_INACT) || tmr_done;

  pbus_phase_timer #(.PH(PH)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (tmr_clr),
    .first_o(tmr_first),
    .done_o (tmr_done)
  );

  pbus_lane_fmt #(.DW(DW)) u_fmt (
    .wsel_i(wsel_q),
    .din_i (wr_data_i),
    .dout_o(fmt_word)
  );

  pbus_rst_pulse #(.RLW(RLW)) u_rstp (
    .clk    (clk),
    .rst    (rst),
    .req_i  (rst_req_i),
    .len_i  (rst_len_i),
    .rst_n_o(disp_rst_n_o)
  );

  assign finish     = (is_cmd_q && !has_data_q) || (!is_cmd_q && last_q);
  assign wr_ready_o = (state_q == S_WAIT);
  assign rd_o       = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      wsel_q      <= W8;
      style6800_q <= 1'b0;
      is_cmd_q    <= 1'b0;
      has_data_q  <= 1'b0;
      last_q      <= 1'b0;
      word_q      <= '0;
      dbus_o      <= '0;
      cs_n_o      <= 1'b1;
      dc_o        <= 1'b0;
      wr_o        <= 1'b1;
      en_o        <= 1'b0;
      busy_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      err_o <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            if (!mode_ok(mode_i)) begin
              err_o <= 1'b1;
            end else if (has_cmd_i || has_data_i) begin
              cs_n_o      <= 1'b0;
              busy_o      <= 1'b1;
              style6800_q <= mode_i[2];
              wsel_q      <= width_e'(mode_i[1:0]);
              is_cmd_q    <= has_cmd_i;
              has_data_q  <= has_data_i;
              last_q      <= 1'b0;
              word_q      <= DW'(cmd_i);
              dc_o        <= !has_cmd_i;
              wr_o        <= !mode_i[2];
              state_q     <= S_LEAD;
            end
          end
        end
        S_LEAD: begin
          if (is_cmd_q) begin
            if (style6800_q) en_o <= 1'b1;
            else             wr_o <= 1'b0;
            state_q <= S_ACT;
          end else begin
            state_q <= S_WAIT;
          end
        end
        S_ACT: begin
          if (tmr_first) dbus_o <= word_q;
          if (tmr_done) begin
            if (style6800_q) en_o <= 1'b0;
            else             wr_o <= 1'b1;
            state_q <= S_INACT;
          end
        end
        S_INACT: begin
          if (tmr_done) begin
            if (finish) begin
              cs_n_o  <= 1'b1;
              busy_o  <= 1'b0;
              dc_o    <= 1'b0;
              dbus_o  <= '0;
              wr_o    <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              is_cmd_q <= 1'b0;
              dc_o     <= 1'b1;
              state_q  <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (wr_valid_i) begin
            word_q <= fmt_word;
            last_q <= wr_last_i;
            if (style6800_q) en_o <= 1'b1;
            else             wr_o <= 1'b0;
            state_q <= S_ACT;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> busy_o); // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (cs_n_o && !busy_o)); // R1
  AST_WR_LATCH_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!style6800_q && $rose(wr_o)) |-> $stable(dbus_o)); // R3
  AST_EN_LATCH_STABLE: assert property (@(posedge clk) disable iff (rst)
    $fell(en_o) |-> $stable(dbus_o)); // R4
  AST_RW_LOW_ON_EN: assert property (@(posedge clk) disable iff (rst)
    en_o |-> (!wr_o && !cs_n_o)); // R4
  AST_DC_LOW_CMD: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ACT && is_cmd_q) |-> !dc_o); // R5
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busy_o && wsel_q == W8) |-> (dbus_o[DW-1:8] == '0)); // R12
  AST_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_ready_o |-> (busy_o && !cs_n_o)); // R11
endmodule

// File: tb/pbus_disp_wr_bench.sv
module pbus_disp_wr_bench;
  localparam int DW = 16;
  localparam int PH = 2;
  localparam int RLW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic has_cmd_i = 1'b0, has_data_i = 1'b0;
  logic [7:0] cmd_i = '0;
  logic wr_valid_i = 1'b0, wr_last_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic rst_req_i = 1'b0;
  logic [RLW-1:0] rst_len_i = '0;
  logic wr_ready_o, busy_o, err_o, cs_n_o, dc_o, wr_o, rd_o, en_o, disp_rst_n_o;
  logic [DW-1:0] dbus_o;

  always #4 clk = ~clk;

  pbus_disp_wr #(.DW(DW), .PHASE_CYC(PH), .RLW(RLW)) u_pbus_disp_wr (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .has_cmd_i(has_cmd_i), .has_data_i(has_data_i), .cmd_i(cmd_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_last_i(wr_last_i),
    .wr_ready_o(wr_ready_o), .busy_o(busy_o), .err_o(err_o),
    .rst_req_i(rst_req_i), .rst_len_i(rst_len_i), .dbus_o(dbus_o),
    .cs_n_o(cs_n_o), .dc_o(dc_o), .wr_o(wr_o), .rd_o(rd_o), .en_o(en_o),
    .disp_rst_n_o(disp_rst_n_o)
  );

  int n_chk = 0, n_err = 0;
  bit fin = 1'b0;
  logic [16:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit mon_6800 = 1'b0;
  logic prev_act = 1'b0, prev_cs_n = 1'b1, cur_act;
  logic [DW-1:0] prev_dbus = '0;
  int run = 0;
  bit run_ok = 1'b0;
  int cs_falls = 0;
  bit dc_hi_seen = 1'b0, rw_bad = 1'b0;
  int rst_low = 0;

  always @(negedge clk) begin
    if (!disp_rst_n_o) rst_low++;
    if (rst) begin
      prev_act = 1'b0; prev_cs_n = 1'b1; prev_dbus = '0; run_ok = 1'b0;
    end else begin
      cur_act = mon_6800 ? en_o : !wr_o;
      if (prev_cs_n && !cs_n_o) begin
        cs_falls++; run_ok = 1'b0; run = 0;
      end
      if (!cs_n_o && dc_o) dc_hi_seen = 1'b1;
      if (mon_6800 && !cs_n_o && wr_o) rw_bad = 1'b1;
      if (prev_act && !cur_act) begin
        chk(dbus_o == prev_dbus, "R10 data stable at latch", dbus_o, prev_dbus);
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected latch", {dc_o, dbus_o}, 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk({dc_o, dbus_o} == e, "R3/R4/R5 latched word", {dc_o, dbus_o}, e);
        end
      end
      if (!cs_n_o) begin
        if (cur_act != prev_act) begin
          if (run_ok) chk(run >= PH, "R10 phase width", run, PH);
          run = 1; run_ok = 1'b1;
        end else run++;
      end
      prev_act = cur_act; prev_cs_n = cs_n_o; prev_dbus = dbus_o;
    end
  end

  function automatic logic [DW-1:0] msk(input logic [DW-1:0] w, input logic [2:0] m);
    case (m[1:0])
      2'd0: return w & 16'h00FF;
      2'd1: return w & 16'h01FF;
      default: return w;
    endcase
  endfunction

  function automatic logic [DW-1:0] word_of(input logic [15:0] seed, input int i);
    return seed ^ 16'((i + 1) * 16'h1F37);
  endfunction

  task automatic run_txn(input logic [2:0] m, input bit hc, input logic [7:0] c,
                         input int n, input logic [15:0] seed, input bit poke, input string tag);
    int guard;
    mon_6800 = m[2];
    cs_falls = 0; dc_hi_seen = 1'b0; rw_bad = 1'b0;
    if (hc) exp_q.push_back({1'b0, 8'h00, c});
    for (int i = 0; i < n; i++) exp_q.push_back({1'b1, msk(word_of(seed, i), m)});
    @(posedge clk); #1;
    start_i = 1'b1; mode_i = m; has_cmd_i = hc; has_data_i = (n > 0); cmd_i = c;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (poke) begin
      start_i = 1'b1; mode_i = 3'b010; has_cmd_i = 1'b1; has_data_i = 1'b1; cmd_i = 8'hEE;
    end
    @(negedge clk);
    chk(busy_o == 1'b1, {"R11 busy after start ", tag}, busy_o, 1);
    chk(wr_ready_o == 1'b0, {"R11 no ready before data phase ", tag}, wr_ready_o, 0);
    chk(cs_n_o == 1'b0, {"R2 cs at start ", tag}, cs_n_o, 0);
    @(posedge clk); #1;
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      wr_valid_i = 1'b1; wr_data_i = word_of(seed, i); wr_last_i = (i == n - 1);
      do @(negedge clk); while (!wr_ready_o);
      @(posedge clk); #1;
      wr_valid_i = 1'b0; wr_last_i = 1'b0;
    end
    guard = 0;
    do begin @(negedge clk); guard++; end while (busy_o && guard < 500);
    chk(cs_n_o == 1'b1, {"R2 cs released with busy ", tag}, cs_n_o, 1);
    chk(exp_q.size() == 0, {"R2 all words latched ", tag}, exp_q.size(), 0);
    chk(cs_falls == 1, {"R2 single cs assertion ", tag}, cs_falls, 1);
    if (m[2]) chk(!rw_bad, {"R4 rw low through txn ", tag}, rw_bad, 0);
    if (n == 0) chk(!dc_hi_seen, {"R7 dc stays low ", tag}, dc_hi_seen, 0);
    exp_q.delete();
    repeat (3) @(posedge clk);
  endtask

  task automatic rst_pulse(input logic [RLW-1:0] len, input bit poke, input logic [RLW-1:0] exp);
    @(posedge clk); #1;
    rst_low = 0; rst_req_i = 1'b1; rst_len_i = len;
    @(posedge clk); #1;
    rst_req_i = 1'b0;
    if (poke) begin
      @(posedge clk); #1; rst_req_i = 1'b1; rst_len_i = 16'd40;
      @(posedge clk); #1; rst_req_i = 1'b0;
    end
    repeat (60) @(posedge clk);
    chk(rst_low == int'(exp), "R9 reset pulse length", rst_low, exp);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!fin) begin
      n_err++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    // R8 idle levels
    chk({wr_o, rd_o, en_o, cs_n_o, dc_o} == 5'b11010, "R8 idle strobes",
        {wr_o, rd_o, en_o, cs_n_o, dc_o}, 5'b11010);
    chk(dbus_o == '0, "R8 idle bus", dbus_o, 0);
    chk({disp_rst_n_o, busy_o, wr_ready_o, err_o} == 4'b1000, "R8 idle status",
        {disp_rst_n_o, busy_o, wr_ready_o, err_o}, 4'b1000);

    run_txn(3'b000, 1'b1, 8'h2C, 3, 16'hF3A5, 1'b0, "R3 R12 strobe 8b");
    run_txn(3'b010, 1'b1, 8'h3A, 4, 16'hBEEF, 1'b0, "R3 R5 strobe 16b");
    run_txn(3'b001, 1'b0, 8'h00, 3, 16'hFFFF, 1'b0, "R6 R12 strobe 9b no cmd");
    run_txn(3'b100, 1'b1, 8'h51, 2, 16'hC3C3, 1'b0, "R4 enable 8b");
    run_txn(3'b110, 1'b1, 8'h01, 0, 16'h0000, 1'b0, "R7 enable cmd only");
    run_txn(3'b101, 1'b0, 8'h00, 1, 16'hFE01, 1'b0, "R4 R6 enable 9b single");
    run_txn(3'b000, 1'b1, 8'h11, 2, 16'h1234, 1'b1, "R11 restart ignored");

    // R1 invalid modes
    for (int k = 0; k < 2; k++) begin
      cs_falls = 0;
      @(posedge clk); #1;
      start_i = 1'b1; mode_i = (k == 0) ? 3'b011 : 3'b111; has_cmd_i = 1'b1; has_data_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      @(negedge clk);
      chk(err_o == 1'b1, "R1 error flag", err_o, 1);
      chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R1 no activity", {cs_n_o, busy_o}, 2'b10);
      repeat (10) @(negedge clk);
      chk(err_o == 1'b0, "R1 error is a pulse", err_o, 0);
      chk(cs_falls == 0 && wr_o && !en_o, "R1 bus quiet", cs_falls, 0);
    end

    rst_pulse(16'd5, 1'b1, 16'd5);
    rst_pulse(16'd1, 1'b0, 16'd1);
    rst_pulse(16'd0, 1'b0, 16'd0);

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule